// File: doc/BRIEF.md
# Floating-Point Status and Exception Controller

This block keeps the 32-bit status word of a single-precision floating-point unit and decides how each finished operation changes it. When an operation retires, the arithmetic datapath hands over five exception indications (invalid, overflow, divide-by-zero, underflow, inexact), a denormal indication, the 32-bit result and, for compares, the relation between the two operands. From these the block sets the per-operation cause bits, accumulates sticky flags, keeps a summary bit, and sends a one-cycle exception request with a fixed vector number when an enabled cause, or the always-enabled unimplemented-processing cause, occurs.

The same operation also sets three condition flags (zero, sign, overflow). Software can rewrite the status word through a write port, but it can never set a cause bit or the summary bit directly. The two-bit rounding field is decoded into a one-hot rounding selection for the datapath. All outputs are registered and change one clock after the inputs that cause them.

Top module: `fp_status_ctrl`

## Requirements
- R1: After reset the status word, the condition flags and the exception request are all zero, and the rounding selection is 4'b0001.
- R2: Each operation clears status bits 7..2 and then sets bit 2+k for each asserted exception input bit k, with the order 0 invalid, 1 overflow, 2 divide-by-zero, 3 underflow, 4 inexact.
- R3: An asserted exception k sets sticky flag bit 26+k only when enable bit 10+k is 0; sticky flags are never cleared by an operation.
- R4: A denormal indication sets the unimplemented cause bit 7 only when the flush bit 8 is 0.
- R5: Status bit 31 (summary) equals the OR of the sticky flags 30..26 at every clock.
- R6: `exc_req` is high for exactly the cycle after an operation whose cause bits include an exception k with enable bit 10+k set, or the unimplemented cause; `exc_vector` is always 21.
- R7: A software write keeps bits 7..2 as the AND of old and written value, ignores written bit 31, loads every other bit from the write data, then recomputes bit 31; an operation in the same cycle is applied first and the write is merged on top.
- R8: `rnd_sel` is one-hot with bit m set for rounding field bits 1..0 equal to m (0 nearest-even, 1 toward zero, 2 toward +infinity, 3 toward -infinity).
- R9: A compare (op_kind 1) with relation 0 equal sets zero, 1 less sets sign, 3 unordered sets overflow, 2 greater sets none; the other two flags are cleared.
- R10: An arithmetic operation (op_kind 0) sets zero when result bits 30..0 are all 0 (so -0.0 counts), sets sign to result bit 31 and leaves the overflow flag unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation retires this cycle |
| op_kind | input | 1 | 0 arithmetic, 1 compare |
| op_exc | input | 5 | Exception indications, order as in R2 |
| op_denorm | input | 1 | Input or output denormal seen |
| op_result | input | 32 | Arithmetic result bits |
| op_rel | input | 2 | Compare relation, encoding as in R9 |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 32 | Software write data |
| status | output | 32 | Current status word |
| rnd_sel | output | 4 | One-hot rounding selection |
| cc_zero | output | 1 | Zero condition flag |
| cc_sign | output | 1 | Sign condition flag |
| cc_ovf | output | 1 | Overflow / unordered condition flag |
| exc_req | output | 1 | One-cycle exception request |
| exc_vector | output | 5 | Exception vector number |

## Verification
The hardest situation to reach is a software write landing in the same cycle as an operation, where the freshly set cause bits must be filtered by the write mask and the summary must be recomputed from flags the operation just raised. The bench reaches it by first loading enables and the flush bit through writes, then issuing operations with a simultaneous write, and by a long run in which writes and operations are drawn independently so they collide often. A behavioural model predicts every output each cycle.

// File: rtl/fpst_pkg.sv
package fpst_pkg;
    localparam int SR_W       = 32;
    localparam int N_EXC      = 5;
    localparam int RM_W       = 2;
    localparam int N_RM       = 1 << RM_W;
    localparam int CAUSE_LSB  = 2;
    localparam int UNIMPL_BIT = CAUSE_LSB + N_EXC;
    localparam int FLUSH_BIT  = UNIMPL_BIT + 1;
    localparam int EN_LSB     = 10;
    localparam int FLAG_LSB   = 26;
    localparam int SUM_BIT    = FLAG_LSB + N_EXC;
    localparam int VEC_W      = 5;

    typedef enum logic [1:0] {
        REL_EQ = 2'd0,
        REL_LT = 2'd1,
        REL_GT = 2'd2,
        REL_UN = 2'd3
    } rel_e;

    typedef struct packed {
        logic [SR_W-1:0] sr;
        logic            cz;
        logic            cs;
        logic            co;
        logic            req;
    } state_t;
endpackage

// File: rtl/fpst_exc_eval.sv
module fpst_exc_eval
    import fpst_pkg::*;
(
    input  logic [SR_W-1:0]  sr_in,
    input  logic [N_EXC-1:0] exc,
    input  logic             denorm,
    output logic [SR_W-1:0]  sr_out,
    output logic             raise
);
    logic [N_EXC-1:0] en_bits;
    logic [N_EXC-1:0] flags_old;
    logic [N_EXC-1:0] flags_new;
    logic             unimpl;

    always_comb begin
        en_bits   = sr_in[EN_LSB +: N_EXC];
        flags_old = sr_in[FLAG_LSB +: N_EXC];
        unimpl    = denorm & ~sr_in[FLUSH_BIT];
        flags_new = flags_old | (exc & ~en_bits);

        sr_out                        = sr_in;
        sr_out[CAUSE_LSB +: N_EXC]    = exc;
        sr_out[UNIMPL_BIT]            = unimpl;
        sr_out[FLAG_LSB +: N_EXC]     = flags_new;
        sr_out[SUM_BIT]               = sr_in[SUM_BIT] | (|flags_new);

        raise = unimpl | (|(exc & en_bits));
    end
endmodule

// File: rtl/fpst_sw_merge.sv
module fpst_sw_merge
    import fpst_pkg::*;
(
    input  logic [SR_W-1:0] sr_in,
    input  logic [SR_W-1:0] wdata,
    output logic [SR_W-1:0] sr_out
);
    localparam int CAUSE_ALL = N_EXC + 1;

    always_comb begin
        sr_out                           = wdata;
        sr_out[CAUSE_LSB +: CAUSE_ALL]   = sr_in[CAUSE_LSB +: CAUSE_ALL]
                                         & wdata[CAUSE_LSB +: CAUSE_ALL];
        sr_out[SUM_BIT]                  = |wdata[FLAG_LSB +: N_EXC];
    end
endmodule

// File: rtl/fpst_round_dec.sv
module fpst_round_dec
    import fpst_pkg::*;
(
    input  logic [RM_W-1:0] rm,
    output logic [N_RM-1:0] sel
);
    for (genvar m = 0; m < N_RM; m++) begin : g_sel
        assign sel[m] = (rm == RM_W'(m));
    end
endmodule

// File: rtl/fpst_cond_eval.sv
module fpst_cond_eval
    import fpst_pkg::*;
(
    input  logic            is_cmp,
    input  logic [1:0]      rel,
    input  logic [SR_W-1:0] result,
    input  logic            co_old,
    output logic            cz,
    output logic            cs,
    output logic            co
);
    always_comb begin
        if (is_cmp) begin
            cz = (rel_e'(rel) == REL_EQ);
            cs = (rel_e'(rel) == REL_LT);
            co = (rel_e'(rel) == REL_UN);
        end else begin
            cz = (result[SR_W-2:0] == '0);
            cs = result[SR_W-1];
            co = co_old;
        end
    end
endmodule

// File: rtl/fp_status_ctrl.sv
module fp_status_ctrl
    import fpst_pkg::*;
#(
    parameter int EXC_VEC_NUM = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic              op_kind,
    input  logic [N_EXC-1:0]  op_exc,
    input  logic              op_denorm,
    input  logic [SR_W-1:0]   op_result,
    input  logic [1:0]        op_rel,
    input  logic              wr_en,
    input  logic [SR_W-1:0]   wr_data,
    output logic [SR_W-1:0]   status,
    output logic [N_RM-1:0]   rnd_sel,
    output logic              cc_zero,
    output logic              cc_sign,
    output logic              cc_ovf,
    output logic              exc_req,
    output logic [VEC_W-1:0]  exc_vector
);
    state_t st_q, st_d;

    logic [SR_W-1:0] sr_eval;
    logic [SR_W-1:0] sr_op;
    logic [SR_W-1:0] sr_wr;
    logic            raise_w;
    logic            cz_w, cs_w, co_w;

    fpst_exc_eval u_eval (
        .sr_in  (st_q.sr),
        .exc    (op_exc),
        .denorm (op_denorm),
        .sr_out (sr_eval),
        .raise  (raise_w)
    );

    assign sr_op = op_valid ? sr_eval : st_q.sr;

    fpst_sw_merge u_merge (
        .sr_in  (sr_op),
        .wdata  (wr_data),
        .sr_out (sr_wr)
    );

    fpst_cond_eval u_cond (
        .is_cmp (op_kind),
        .rel    (op_rel),
        .result (op_result),
        .co_old (st_q.co),
        .cz     (cz_w),
        .cs     (cs_w),
        .co     (co_w)
    );

    fpst_round_dec u_rnd (
        .rm  (st_q.sr[RM_W-1:0]),
        .sel (rnd_sel)
    );

    always_comb begin
        st_d     = st_q;
        st_d.req = 1'b0;
        st_d.sr  = wr_en ? sr_wr : sr_op;
        if (op_valid) begin
            st_d.req = raise_w;
            st_d.cz  = cz_w;
            st_d.cs  = cs_w;
            st_d.co  = co_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status     = st_q.sr;
    assign cc_zero    = st_q.cz;
    assign cc_sign    = st_q.cs;
    assign cc_ovf     = st_q.co;
    assign exc_req    = st_q.req;
    assign exc_vector = VEC_W'(EXC_VEC_NUM);

    assert_summary_R5: assert property (@(posedge clk) disable iff (!rst_n)
        status[SUM_BIT] == (|status[FLAG_LSB +: N_EXC]));

    assert_req_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && raise_w) |=> exc_req);

    assert_req_only_after_op_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !exc_req);

    assert_cause_no_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !op_valid) |=>
        ((status[UNIMPL_BIT:CAUSE_LSB] & ~$past(status[UNIMPL_BIT:CAUSE_LSB])) == '0));

    assert_flags_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=>
        (($past(status[FLAG_LSB +: N_EXC]) & ~status[FLAG_LSB +: N_EXC]) == '0));

    assert_cmp_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind) |=> $onehot0({cc_zero, cc_sign, cc_ovf}));
endmodule

// File: tb/fp_status_ctrl_bench.sv
module fp_status_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic        op_kind = 1'b0;
    logic [4:0]  op_exc = '0;
    logic        op_denorm = 1'b0;
    logic [31:0] op_result = '0;
    logic [1:0]  op_rel = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] status;
    logic [3:0]  rnd_sel;
    logic        cc_zero, cc_sign, cc_ovf, exc_req;
    logic [4:0]  exc_vector;

    always #2 clk = ~clk;

    fp_status_ctrl u_fp_status_ctrl (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .op_exc(op_exc), .op_denorm(op_denorm), .op_result(op_result),
        .op_rel(op_rel), .wr_en(wr_en), .wr_data(wr_data), .status(status),
        .rnd_sel(rnd_sel), .cc_zero(cc_zero), .cc_sign(cc_sign),
        .cc_ovf(cc_ovf), .exc_req(exc_req), .exc_vector(exc_vector)
    );

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    bit [31:0] m_sr = '0;
    bit        m_z = 0, m_s = 0, m_o = 0, m_req = 0;

    task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all();
        cmp("R2/R3/R4/R5/R7 status", status, m_sr);
        cmp("R8 rnd_sel", 32'(rnd_sel), 32'(1) << m_sr[1:0]);
        cmp("R9/R10 cc_zero", 32'(cc_zero), 32'(m_z));
        cmp("R9/R10 cc_sign", 32'(cc_sign), 32'(m_s));
        cmp("R9/R10 cc_ovf", 32'(cc_ovf), 32'(m_o));
        cmp("R6 exc_req", 32'(exc_req), 32'(m_req));
        cmp("R6 exc_vector", 32'(exc_vector), 32'd21);
    endtask

    // Behavioural model: one clock of the requirements
    task automatic model_step();
        bit [31:0] s = m_sr;
        bit any_flag;
        m_req = 0;
        if (op_valid) begin
            for (int b = 2; b <= 7; b++) s[b] = 0;          // R2 clear
            for (int k = 0; k < 5; k++) begin
                if (op_exc[k]) begin
                    s[2+k] = 1;                              // R2
                    if (!m_sr[10+k]) s[26+k] = 1;            // R3
                    else m_req = 1;                          // R6
                end
            end
            if (op_denorm && !m_sr[8]) begin s[7] = 1; m_req = 1; end // R4
            if (op_kind) begin                               // R9
                m_z = (op_rel == 2'd0);
                m_s = (op_rel == 2'd1);
                m_o = (op_rel == 2'd3);
            end else begin                                   // R10
                m_z = (op_result[30:0] == 0);
                m_s = op_result[31];
            end
        end
        if (wr_en) begin                                     // R7
            for (int b = 0; b < 31; b++) begin
                if (b >= 2 && b <= 7) s[b] = s[b] & wr_data[b];
                else s[b] = wr_data[b];
            end
        end
        any_flag = 0;
        for (int k = 26; k <= 30; k++) any_flag |= s[k];
        s[31] = any_flag;                                    // R5
        m_sr = s;
    endtask

    task automatic step(bit v, bit kind, bit [4:0] e, bit dn, bit [31:0] res,
                        bit [1:0] rel, bit w, bit [31:0] wd);
        op_valid = v; op_kind = kind; op_exc = e; op_denorm = dn;
        op_result = res; op_rel = rel; wr_en = w; wr_data = wd;
        model_step();
        @(posedge clk);
        @(negedge clk);
        check_all();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_all();                                   // R1 reset state
        rst_n = 1'b1;
        step(0, 0, 0, 0, 0, 0, 0, 0);                  // R1 idle
        // R2 R3: each exception alone, enables clear
        for (int k = 0; k < 5; k++) step(1, 0, 5'(1 << k), 0, 32'h3f800000, 0, 0, 0);
        step(1, 0, 0, 0, 32'h0, 0, 0, 0);              // R2 causes cleared
        // R7: clear flags, try to set causes and summary, load enables
        step(0, 0, 0, 0, 0, 0, 1, 32'h8000_7cfc);
        // R6: enabled exceptions raise request, flags untouched (R3)
        step(1, 0, 5'b00101, 0, 32'h1, 0, 0, 0);
        step(1, 0, 5'b11010, 0, 32'h1, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0, 0);                  // R6 single pulse
        // R4: denormal with flush clear then set
        step(0, 0, 0, 0, 0, 0, 1, 32'h0);
        step(1, 0, 0, 1, 32'h0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 1, 32'h0000_0100);
        step(1, 0, 0, 1, 32'h0, 0, 0, 0);
        // R8: all rounding modes
        for (int m = 0; m < 4; m++) step(0, 0, 0, 0, 0, 0, 1, 32'(m));
        // R9: compares, all relations
        for (int r = 0; r < 4; r++) step(1, 1, 0, 0, 0, 2'(r), 0, 0);
        // R10: -0.0, +0, negative, positive; overflow flag kept
        step(1, 1, 0, 0, 0, 2'd3, 0, 0);
        step(1, 0, 0, 0, 32'h8000_0000, 0, 0, 0);
        step(1, 0, 0, 0, 32'h0000_0000, 0, 0, 0);
        step(1, 0, 0, 0, 32'hc000_0000, 0, 0, 0);
        step(1, 0, 0, 0, 32'h4000_0001, 0, 0, 0);
        // R7: write and operation in the same cycle
        step(1, 0, 5'b11111, 1, 32'h1, 0, 1, 32'hffff_ffff);
        step(1, 0, 5'b01001, 0, 32'h1, 0, 1, 32'h0000_0fff);
        // Mixed random traffic
        for (int i = 0; i < 3000; i++) begin
            bit [31:0] r = $urandom;
            bit [31:0] wd = $urandom;
            step(r[0], r[1], r[6:2], r[7], (r[8] ? 32'h8000_0000 : $urandom),
                 r[10:9], (r[13:11] == 0), wd);
        end
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule